// File: doc/BRIEF.md
# Software Sync Pulse and Self-Test Input Control

This block sits between the host write path and four receive channels. It holds one 8-bit control byte that can only be written, never read back. One write can send a single-cycle start pulse, a single-cycle frequency-hop pulse, or both, to any chosen subset of channels. Each pulse goes to that channel's hold-off counter. A hardware sync pin for each channel is merged with these software pulses.

The same byte selects the sample stream that every channel receives. The stream is either the normal converter samples or an internal test word. The test word is either a constant negative full-scale value or the output of a 16-bit pseudorandom sequence generator.

A two-state machine produces the pulses. It sits in `SYNC_IDLE` until a write sets a pulse bit, then takes transition ARM into `SYNC_FIRE`. `SYNC_FIRE` lasts one cycle per such write. A further pulse-bearing write moves it along REFIRE and it stays in `SYNC_FIRE`. Otherwise it returns to `SYNC_IDLE` by transition DONE.

Top module: `soft_sync_bist`

## Requirements
- R1: After reset the machine is in `SYNC_IDLE`, every channel enable is clear and test mode is off. So `start_sync` and `hop_sync` equal `hw_sync`, and `ch_data` equals `adc_in`.
- R2: A write (`wr_en` high for one cycle) with bit 4 set makes `start_sync[c]` high in the cycle after the write edge, for each channel c whose bit c (bits 3..0) was set in that same write.
- R3: A write with bit 5 set makes `hop_sync[c]` high in the cycle after the write edge, for each channel c whose enable bit was set in that write.
- R4: A channel whose enable bit was clear in the write gets no software pulse. A write with bits 5 and 4 both clear produces no software pulse on any channel.
- R5: Every software pulse lasts exactly one cycle and does not recur without a new write. Writes on consecutive cycles give pulses on consecutive cycles, each using its own write's enables.
- R6: Each bit of `start_sync` and `hop_sync` is the OR of the matching `hw_sync` bit and that channel's software pulse.
- R7: When bit 6 of the last write is 0, `ch_data` slice c equals `adc_in` slice c for every channel.
- R8: When bit 6 is 1 and bit 7 is 0, every channel slice of `ch_data` equals 16'h8000, whatever `adc_in` holds.
- R9: When bits 7 and 6 are both 1, every channel slice carries the same pseudorandom word, which is never zero. From one cycle to the next the word v becomes {v[14:0], v[15]^v[13]^v[12]^v[10]}.
- R10: Each write replaces the channel enables and both test-mode bits together, and they hold their values across cycles without writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte: bits 3..0 channel enables, 4 start, 5 hop, 6 test select, 7 pattern select |
| hw_sync | input | NUM_CH | Hardware sync pin per channel |
| adc_in | input | NUM_CH*DW | Converter samples, channel c at bits c*DW upward |
| start_sync | output | NUM_CH | Start hold-off trigger per channel |
| hop_sync | output | NUM_CH | Hop hold-off trigger per channel |
| ch_data | output | NUM_CH*DW | Samples delivered to the channels |

## Verification
The pulse logic is exercised with several write patterns:
- a start-only write to an alternating subset of channels;
- a hop-only write to the complementary subset;
- a write that sets both pulse bits for all channels;
- a write with enables but no pulse bits, and a write with pulse bits but no enables.

Together these separate the start path from the hop path, check the enable gating, and check that pulses are suppressed when nothing should fire. Back-to-back writes with different enable masks show whether each pulse takes its own write's mask and whether the machine re-arms without a gap. Driving the hardware pin with and without a software pulse distinguishes the OR merge from a replacement.

On the data side, `adc_in` is changed while in bypass and while in full-scale mode, to show which source is selected. The pseudorandom stream is followed step by step against the stated recurrence.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;
    typedef enum logic [0:0] {
        SYNC_IDLE = 1'b0,
        SYNC_FIRE = 1'b1
    } sync_state_e;

    localparam int CTRL_W   = 8;
    localparam int BIT_STRT = 4;
    localparam int BIT_HOP  = 5;
    localparam int BIT_TEST = 6;
    localparam int BIT_PN   = 7;
endpackage

// File: rtl/ssc_ctrl_reg.sv
`timescale 1ns/1ps
module ssc_ctrl_reg
    import ssc_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [NUM_CH-1:0] ch_en,
    output logic              start_req,
    output logic              hop_req,
    output logic              test_en,
    output logic              pn_sel
);
    sync_state_e state, state_nx;
    logic        start_flag, hop_flag;
    logic        fire_req;

    assign fire_req = wr_en & (wr_data[BIT_STRT] | wr_data[BIT_HOP]);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SYNC_IDLE;
        else        state <= state_nx;
    end

    // Next state: ARM, REFIRE, DONE
    always_comb begin
        state_nx = state;
        unique case (state)
            SYNC_IDLE: if (fire_req) state_nx = SYNC_FIRE;
            SYNC_FIRE: state_nx = fire_req ? SYNC_FIRE : SYNC_IDLE;
        endcase
    end

    // Fields captured on every write; pulse bits only count in SYNC_FIRE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_en      <= '0;
            start_flag <= 1'b0;
            hop_flag   <= 1'b0;
            test_en    <= 1'b0;
            pn_sel     <= 1'b0;
        end else if (wr_en) begin
            ch_en      <= wr_data[NUM_CH-1:0];
            start_flag <= wr_data[BIT_STRT];
            hop_flag   <= wr_data[BIT_HOP];
            test_en    <= wr_data[BIT_TEST];
            pn_sel     <= wr_data[BIT_PN];
        end
    end

    // Outputs
    always_comb begin
        start_req = 1'b0;
        hop_req   = 1'b0;
        unique case (state)
            SYNC_IDLE: ;
            SYNC_FIRE: begin
                start_req = start_flag;
                hop_req   = hop_flag;
            end
        endcase
    end
endmodule

// File: rtl/ssc_lfsr.sv
`timescale 1ns/1ps
module ssc_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] q
);
    logic fb;
    assign fb = ^(q & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEED;
        else        q <= {q[W-2:0], fb};
    end
endmodule

// File: rtl/ssc_test_mux.sv
`timescale 1ns/1ps
module ssc_test_mux #(
    parameter int NUM_CH = 4,
    parameter int DW     = 16
) (
    input  logic                 test_en,
    input  logic                 pn_sel,
    input  logic [DW-1:0]        pn_word,
    input  logic [NUM_CH*DW-1:0] adc_in,
    output logic [NUM_CH*DW-1:0] ch_data
);
    localparam logic [DW-1:0] NEG_FS = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] test_word;
    assign test_word = pn_sel ? pn_word : NEG_FS;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_data[c*DW +: DW] = test_en ? test_word : adc_in[c*DW +: DW];
    end
endmodule

// File: rtl/soft_sync_bist.sv
`timescale 1ns/1ps
module soft_sync_bist
    import ssc_pkg::*;
#(
    parameter int           NUM_CH = 4,
    parameter int           DW     = 16,
    parameter logic [DW-1:0] SEED  = 16'hACE1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    input  logic [NUM_CH-1:0]    hw_sync,
    input  logic [NUM_CH*DW-1:0] adc_in,
    output logic [NUM_CH-1:0]    start_sync,
    output logic [NUM_CH-1:0]    hop_sync,
    output logic [NUM_CH*DW-1:0] ch_data
);
    logic [NUM_CH-1:0] ch_en;
    logic              start_req, hop_req, test_en, pn_sel;
    logic [DW-1:0]     pn_word;

    ssc_ctrl_reg #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ch_en     (ch_en),
        .start_req (start_req),
        .hop_req   (hop_req),
        .test_en   (test_en),
        .pn_sel    (pn_sel)
    );

    ssc_lfsr #(.W(DW), .TAPS(16'hB400), .SEED(SEED)) u_pn (
        .clk   (clk),
        .rst_n (rst_n),
        .q     (pn_word)
    );

    ssc_test_mux #(.NUM_CH(NUM_CH), .DW(DW)) u_mux (
        .test_en (test_en),
        .pn_sel  (pn_sel),
        .pn_word (pn_word),
        .adc_in  (adc_in),
        .ch_data (ch_data)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sync
        assign start_sync[c] = hw_sync[c] | (start_req & ch_en[c]);
        assign hop_sync[c]   = hw_sync[c] | (hop_req   & ch_en[c]);
    end
endmodule

// File: rtl/soft_sync_bist_chk.sv
`timescale 1ns/1ps
module soft_sync_bist_chk #(
    parameter int NUM_CH = 4,
    parameter int DW     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [7:0]           wr_data,
    input logic [NUM_CH-1:0]    hw_sync,
    input logic [NUM_CH*DW-1:0] adc_in,
    input logic [NUM_CH-1:0]    start_sync,
    input logic [NUM_CH-1:0]    hop_sync,
    input logic [NUM_CH*DW-1:0] ch_data
);
    p_start_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[4]) |=>
            ((start_sync & $past(wr_data[NUM_CH-1:0])) == $past(wr_data[NUM_CH-1:0])));

    p_hop_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[5]) |=>
            ((hop_sync & $past(wr_data[NUM_CH-1:0])) == $past(wr_data[NUM_CH-1:0])));

    p_no_pulse_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[4] && !wr_data[5]) |=>
            (start_sync == hw_sync && hop_sync == hw_sync));

    p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (start_sync == hw_sync && hop_sync == hw_sync));

    p_hw_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_sync & hw_sync) == hw_sync) && ((hop_sync & hw_sync) == hw_sync));

    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[6]) |=> (ch_data == adc_in));

    p_fullscale_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7:6] == 2'b01) |=> (ch_data[DW-1:0] == {1'b1, {(DW-1){1'b0}}}));

    p_pn_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7:6] == 2'b11) |=> (ch_data[DW-1:0] != '0));
endmodule

bind soft_sync_bist soft_sync_bist_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .hw_sync    (hw_sync),
    .adc_in     (adc_in),
    .start_sync (start_sync),
    .hop_sync   (hop_sync),
    .ch_data    (ch_data)
);

// File: tb/sim_soft_sync_bist.sv
`timescale 1ns/1ps
module sim_soft_sync_bist;
    localparam int NCH = 4;
    localparam int DW  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic [NCH-1:0]   hw_sync = '0;
    logic [NCH*DW-1:0] adc_in = '0;
    logic [NCH-1:0]   start_sync, hop_sync;
    logic [NCH*DW-1:0] ch_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    soft_sync_bist u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hw_sync(hw_sync), .adc_in(adc_in),
        .start_sync(start_sync), .hop_sync(hop_sync), .ch_data(ch_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pn_step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // write lands on the next posedge; returns at the following negedge
    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        adc_in = 64'h1111_2222_3333_4444;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(start_sync == 4'h0, "R1 start_sync after reset", start_sync, 0);
        chk(hop_sync == 4'h0, "R1 hop_sync after reset", hop_sync, 0);
        chk(ch_data == adc_in, "R1 ch_data after reset", ch_data, adc_in);
    endtask

    task automatic t_start();
        wr(8'h15);
        chk(start_sync == 4'b0101, "R2 start pulse subset", start_sync, 4'b0101);
        chk(hop_sync == 4'b0000, "R3 no hop on start write", hop_sync, 0);
        @(negedge clk);
        chk(start_sync == 4'b0000, "R5 start pulse cleared", start_sync, 0);
    endtask

    task automatic t_hop();
        wr(8'h2A);
        chk(hop_sync == 4'b1010, "R3 hop pulse subset", hop_sync, 4'b1010);
        chk(start_sync == 4'b0000, "R2 no start on hop write", start_sync, 0);
        @(negedge clk);
        chk(hop_sync == 4'b0000, "R5 hop pulse cleared", hop_sync, 0);
    endtask

    task automatic t_gating();
        wr(8'h3F);
        chk(start_sync == 4'hF && hop_sync == 4'hF, "R2 R3 both pulses all channels",
            {start_sync, hop_sync}, 8'hFF);
        wr(8'h0F);
        chk(start_sync == 0 && hop_sync == 0, "R4 enables without pulse bits",
            {start_sync, hop_sync}, 0);
        wr(8'h30);
        chk(start_sync == 0 && hop_sync == 0, "R4 pulse bits without enables",
            {start_sync, hop_sync}, 0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h13;
        @(negedge clk);
        wr_data = 8'h18;
        chk(start_sync == 4'b0011, "R5 first of back-to-back", start_sync, 4'b0011);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        chk(start_sync == 4'b1000, "R5 second of back-to-back", start_sync, 4'b1000);
        @(negedge clk);
        chk(start_sync == 4'b0000, "R5 no repeat after pair", start_sync, 0);
    endtask

    task automatic t_hw();
        @(negedge clk);
        hw_sync = 4'b0110;
        #1;
        chk(start_sync == 4'b0110 && hop_sync == 4'b0110, "R6 hw pin alone",
            {start_sync, hop_sync}, 8'h66);
        wr(8'h11);
        chk(start_sync == 4'b0111, "R6 hw OR start", start_sync, 4'b0111);
        chk(hop_sync == 4'b0110, "R6 hw only on hop", hop_sync, 4'b0110);
        @(negedge clk);
        hw_sync = '0;
    endtask

    task automatic t_bypass();
        wr(8'h80);
        chk(ch_data == adc_in, "R7 bypass with pattern bit set", ch_data, adc_in);
        adc_in = 64'hDEAD_BEEF_0123_7FFF;
        #1;
        chk(ch_data == adc_in, "R7 bypass follows adc_in", ch_data, adc_in);
    endtask

    task automatic t_fullscale();
        wr(8'h40);
        for (int c = 0; c < NCH; c++)
            chk(ch_data[c*DW +: DW] == 16'h8000, "R8 full-scale word", ch_data[c*DW +: DW], 16'h8000);
        adc_in = 64'h0F0F_F0F0_5555_AAAA;
        repeat (4) @(negedge clk);
        chk(ch_data == {4{16'h8000}}, "R10 test mode held without writes", ch_data, {4{16'h8000}});
        wr(8'h01);
        chk(ch_data == adc_in, "R10 new write restores bypass", ch_data, adc_in);
    endtask

    task automatic t_pn();
        logic [15:0] v;
        wr(8'hC0);
        v = ch_data[15:0];
        for (int i = 0; i < 24; i++) begin
            chk(v != 16'h0, "R9 pn word nonzero", v, 1);
            for (int c = 1; c < NCH; c++)
                chk(ch_data[c*DW +: DW] == v, "R9 pn same on all channels", ch_data[c*DW +: DW], v);
            @(negedge clk);
            chk(ch_data[15:0] == pn_step(v), "R9 pn recurrence", ch_data[15:0], pn_step(v));
            v = ch_data[15:0];
        end
    endtask

    initial begin
        t_reset();
        t_start();
        t_hop();
        t_gating();
        t_back_to_back();
        t_hw();
        t_bypass();
        t_fullscale();
        t_pn();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule